// File: doc/BRIEF.md
# Strobe-Selected Three-Bus Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit that sits between two operand buses and one result bus of a processor datapath. It computes four operations: bitwise AND, bitwise OR, bitwise complement of the first operand, and binary addition. There is no encoded opcode. Each operation has its own enable strobe, and each strobe places only its own result on the shared result bus. The bus drive is modelled in a form that can be synthesized: every result is masked by its enable, and the masked results are ORed together.

With no strobe raised the unit is idle. The result bus then reads as zero and a valid indication stays low. Exactly one raised strobe is the normal working case. Two or more raised strobes are a control fault. The unit flags this condition, and the result bus then carries the OR of all selected results. The adder also produces a carry out of its top bit. That carry is reported only while addition is the sole active operation.

Top module: `tribus_alu`

## Requirements
- R1: With only `and_en_i` high, `res_o` equals `opa_i & opb_i` in every bit position.
- R2: With only `or_en_i` high, `res_o` equals `opa_i | opb_i` in every bit position.
- R3: With only `not_en_i` high, `res_o` equals `~opa_i`, and `opb_i` has no effect on the result.
- R4: With only `add_en_i` high, `res_o` equals `(opa_i + opb_i) mod 2^32`.
- R5: `carry_o` equals the carry out of bit 31 of `opa_i + opb_i` while `add_en_i` is the only strobe high. In every other case `carry_o` is 0.
- R6: With all four strobes low, `res_o` is zero, `res_valid_o` is 0 and `ctrl_err_o` is 0.
- R7: `res_valid_o` is 1 exactly when one strobe is high. It is never 1 at the same time as `ctrl_err_o`.
- R8: With two or more strobes high, `ctrl_err_o` is 1 and `res_o` is the bitwise OR of the results of all the selected operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand bus |
| opb_i | input | 32 | Second operand bus (not used by the complement operation) |
| and_en_i | input | 1 | Strobe that selects bitwise AND |
| or_en_i | input | 1 | Strobe that selects bitwise OR |
| not_en_i | input | 1 | Strobe that selects the complement of opa_i |
| add_en_i | input | 1 | Strobe that selects addition |
| res_o | output | 32 | Result bus: OR of the enabled results, zero when idle |
| res_valid_o | output | 1 | High when exactly one strobe is high |
| ctrl_err_o | output | 1 | High when two or more strobes are high |
| carry_o | output | 1 | Carry out of the adder, qualified by add being the only strobe |

## Verification
The adder and a logic operation can be selected in the same cycle. The carry qualification and the bus merge then interact: the carry must drop to zero and the error flag must rise, while the bus carries the OR of the sum and the logic result. The bench sweeps all sixteen strobe combinations against every operand pattern, so each overlap is provoked with carry-producing sums and with all-ones and all-zeros operands. Each overlap is judged against an OR of results computed separately in the bench, together with the expected valid, error and carry levels.

// File: rtl/tribus_alu_pkg.sv
package tribus_alu_pkg;
  localparam int unsigned N_OPS  = 4;
  localparam int unsigned OP_AND = 0;
  localparam int unsigned OP_OR  = 1;
  localparam int unsigned OP_NOT = 2;
  localparam int unsigned OP_ADD = 3;
  localparam int unsigned CNT_W  = $clog2(N_OPS + 1);
  typedef logic [N_OPS-1:0] op_strb_t;
endpackage

// File: rtl/tribus_logic_slice.sv
module tribus_logic_slice #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] not_o
);
  // one identical cell per bit; no lateral dependence
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign and_o[k] = opa_i[k] & opb_i[k];
    assign or_o[k]  = opa_i[k] | opb_i[k];
    assign not_o[k] = ~opa_i[k];
  end
endmodule

// File: rtl/tribus_adder.sv
module tribus_adder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  logic [DATA_W:0] full;
  assign full   = {1'b0, opa_i} + {1'b0, opb_i};
  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];
endmodule

// File: rtl/tribus_ctrl_check.sv
module tribus_ctrl_check
  import tribus_alu_pkg::*;
(
  input  op_strb_t strb_i,
  output logic     one_o,
  output logic     multi_o
);
  logic [CNT_W-1:0] cnt;
  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(N_OPS); i++) cnt = cnt + CNT_W'(strb_i[i]);
  end
  assign one_o   = (cnt == CNT_W'(1));
  assign multi_o = (cnt > CNT_W'(1));

  always_comb begin
    if (!$isunknown(strb_i)) begin
      AST_ONE_MULTI_EXCL: assert (!(one_o && multi_o)); // R7
      AST_IDLE_QUIET: assert ((strb_i != '0) || (!one_o && !multi_o)); // R6
    end
  end
endmodule

// File: rtl/tribus_bus_drive.sv
module tribus_bus_drive
  import tribus_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  op_strb_t                       en_i,
  input  logic [N_OPS-1:0][DATA_W-1:0]   res_i,
  output logic [DATA_W-1:0]              bus_o
);
  logic [N_OPS-1:0][DATA_W-1:0] gated;
  // each source drives the bus only through its own enable
  for (genvar i = 0; i < N_OPS; i++) begin : g_drv
    assign gated[i] = res_i[i] & {DATA_W{en_i[i]}};
  end
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < int'(N_OPS); i++) bus_o = bus_o | gated[i];
  end

  always_comb begin
    if (!$isunknown(en_i)) begin
      AST_BUS_IDLE_ZERO: assert ((en_i != '0) || (bus_o == '0)); // R6
    end
  end
endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              and_en_i,
  input  logic              or_en_i,
  input  logic              not_en_i,
  input  logic              add_en_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic              ctrl_err_o,
  output logic              carry_o
);
  op_strb_t                     strb;
  logic [N_OPS-1:0][DATA_W-1:0] res;
  logic                         cout;
  logic                         one;

  always_comb begin
    strb         = '0;
    strb[OP_AND] = and_en_i;
    strb[OP_OR]  = or_en_i;
    strb[OP_NOT] = not_en_i;
    strb[OP_ADD] = add_en_i;
  end

  tribus_logic_slice #(.DATA_W(DATA_W)) u_logic (
    .opa_i (opa_i),
    .opb_i (opb_i),
    .and_o (res[OP_AND]),
    .or_o  (res[OP_OR]),
    .not_o (res[OP_NOT])
  );

  tribus_adder #(.DATA_W(DATA_W)) u_add (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .sum_o  (res[OP_ADD]),
    .cout_o (cout)
  );

  tribus_ctrl_check u_chk (
    .strb_i  (strb),
    .one_o   (one),
    .multi_o (ctrl_err_o)
  );

  tribus_bus_drive #(.DATA_W(DATA_W)) u_bus (
    .en_i  (strb),
    .res_i (res),
    .bus_o (res_o)
  );

  assign res_valid_o = one;
  assign carry_o     = cout & add_en_i & one;

  always_comb begin
    if (!$isunknown({strb, opa_i, opb_i})) begin
      AST_CARRY_QUAL: assert (!carry_o || (add_en_i && res_valid_o)); // R5
      AST_AND_SUBSET: assert (!(strb == op_strb_t'(1 << OP_AND)) || ((res_o & ~opa_i) == '0)); // R1
      AST_OR_SUPERSET: assert (!(strb == op_strb_t'(1 << OP_OR)) || ((opb_i & ~res_o) == '0)); // R2
      AST_NOT_DISJOINT: assert (!(strb == op_strb_t'(1 << OP_NOT)) || ((res_o & opa_i) == '0)); // R3
      AST_ERR_NOT_VALID: assert (!(ctrl_err_o && res_valid_o)); // R8
    end
  end
endmodule

// File: tb/tb_tribus_alu.sv
`timescale 1ns/1ps
module tb_tribus_alu;
  localparam int W = 32;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opa, opb, res;
  logic and_en, or_en, not_en, add_en, valid, err, carry;
  int n_chk = 0;
  int n_fail = 0;

  tribus_alu #(.DATA_W(W)) dut (
    .opa_i(opa), .opb_i(opb),
    .and_en_i(and_en), .or_en_i(or_en), .not_en_i(not_en), .add_en_i(add_en),
    .res_o(res), .res_valid_o(valid), .ctrl_err_o(err), .carry_o(carry)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h strb=%b%b%b%b)",
               req, act, exp, opa, opb, add_en, not_en, or_en, and_en);
    end
  endtask

  function automatic logic [W-1:0] pat(input int idx);
    logic [W-1:0] x;
    case (idx)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_0046;
      3: return 32'h0000_007A;
      4: return 32'h8000_0000;
      5: return 32'h7FFF_FFFF;
      6: return 32'h0000_0001;
      7: return 32'hAAAA_5555;
      default: begin
        x = 32'(idx) * 32'h9E37_79B9 + 32'h1234_5678;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
      end
    endcase
  endfunction

  task automatic apply(input logic [3:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    {add_en, not_en, or_en, and_en} = s;
    opa = a; opb = b;
    #1;
  endtask

  initial begin
    opa = '0; opb = '0; and_en = 0; or_en = 0; not_en = 0; add_en = 0;
    apply(4'b0000, '0, '0);
    chk("R6 reset-idle res", res, '0);
    chk("R6 reset-idle valid", {31'd0, valid}, '0);
    chk("R6 reset-idle err", {31'd0, err}, '0);

    // bit examples from the requirements
    apply(4'b0001, 32'h46, 32'h7A); chk("R1 example", res, 32'h42);
    apply(4'b0010, 32'h46, 32'h7A); chk("R2 example", res, 32'h7E);
    apply(4'b0100, 32'h7A, 32'h0);  chk("R3 example", res, 32'hFFFF_FF85);
    apply(4'b1000, 32'hFFFF_FFFF, 32'h1); chk("R4 wrap", res, 32'h0);
    chk("R5 wrap carry", {31'd0, carry}, 32'd1);
    apply(4'b1001, 32'hFFFF_FFFF, 32'h1); chk("R5 carry masked by and", {31'd0, carry}, 32'd0);

    // R3: opb ignored for complement
    for (int j = 0; j < 24; j++) begin
      apply(4'b0100, 32'h1357_9BDF, pat(j));
      chk("R3 opb ignored", res, 32'hECA8_6420);
    end

    for (int s = 0; s < 16; s++) begin
      for (int i = 0; i < 24; i++) begin
        for (int j = 0; j < 24; j += 3) begin
          logic [W-1:0] a, b, e;
          logic [W:0] sum;
          int nsel;
          a = pat(i); b = pat(j + (i % 3));
          sum = {1'b0, a} + {1'b0, b};
          nsel = s[0] + s[1] + s[2] + s[3];
          e = '0;
          if (s[0]) e = e | (a & b);
          if (s[1]) e = e | (a | b);
          if (s[2]) e = e | ~a;
          if (s[3]) e = e | sum[W-1:0];
          apply(4'(s), a, b);
          if (nsel == 0) chk("R6 idle res", res, '0);
          else if (nsel == 1) begin
            if (s[0]) chk("R1 and", res, e);
            if (s[1]) chk("R2 or", res, e);
            if (s[2]) chk("R3 not", res, e);
            if (s[3]) chk("R4 add", res, e);
          end else chk("R8 merged bus", res, e);
          chk("R7 valid", {31'd0, valid}, {31'd0, nsel == 1});
          chk("R8 ctrl_err", {31'd0, err}, {31'd0, nsel > 1});
          chk("R5 carry", {31'd0, carry}, {31'd0, (s == 8) && sum[W]});
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule